// File: doc/BRIEF.md
# Serviced Countdown Watchdog

This block is a countdown watchdog timer that software has to service at regular intervals. A down-counter is loaded from a timeout value. It decrements either on every clock or once per prescaler period. If it expires before software services it, the block raises either a one-cycle nonmaskable interrupt request or a sticky system reset request. A single configuration byte chooses this action, the freeze behaviour, the prescaler and the enable.

The block comes out of reset already running, with the reset action selected. Software that wants a different mode, or no watchdog at all, must write the configuration once. Every later configuration write is dropped, so runaway code cannot turn the timer off. Servicing takes two writes to the service port in a fixed order. A debug freeze input can pause the counter and the prescaler together, when the configuration allows it.

Top module: `svc_watchdog`

## Requirements
- R1: After reset, rd_cfg reads 4'b0101 (bit 0 enable = 1, bit 1 freeze-response = 0, bit 2 action = 1, bit 3 prescale = 0). rd_count equals the parameter TMO_RST. nmi_req and rst_req are low.
- R2: When the freeze-response bit (rd_cfg bit 1) is 1 and freeze_in is high, both the counter and the prescaler hold their values. When that bit is 0, freeze_in has no effect and counting continues.
- R3: Expiry happens on a count step taken while the counter is 0. With the action bit (bit 2) at 0, nmi_req goes high in the following cycle. With it at 1, rst_req goes high in the following cycle.
- R4: With the prescale bit (bit 3) at 0, the counter decrements by one on every clock. With it at 1, the counter decrements once every PRE_DIV clocks.
- R5: The first cfg_we after reset loads cfg_wdata and cfg_tmo. Every later cfg_we until the next reset is ignored.
- R6: A svc_we with 16'h556C, followed by a svc_we with 16'hAA39, reloads the counter from the timeout value at the edge of the second write and clears the prescaler. Any other value written in between restarts the sequence.
- R7: nmi_req is high for exactly one cycle per expiry. The counter reloads at the expiry edge and keeps running. Once rst_req is set, it stays high until rst.
- R8: While the enable bit is 0, rd_count equals the timeout value and no new request is raised.
- R9: rd_count shows the live counter value and rd_cfg shows the stored configuration bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze_in | input | 1 | Debug freeze request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Configuration bits: enable, freeze-response, action, prescale (bits 0..3) |
| cfg_tmo | input | CNT_W | Timeout value loaded with the configuration |
| svc_we | input | 1 | Service write strobe |
| svc_wdata | input | 16 | Service key value |
| nmi_req | output | 1 | One-cycle nonmaskable interrupt request |
| rst_req | output | 1 | Sticky system reset request |
| rd_count | output | CNT_W | Current counter value |
| rd_cfg | output | 4 | Stored configuration bits |

## Verification
The bench builds the block with TMO_RST = 40 and PRE_DIV = 8, keeping CNT_W at 16. The short reset timeout lets the default reset action fire within a few dozen cycles. The small prescaler brings prescaled expiries, and prescaler wrap during freeze, within reach of a few thousand random cycles. Random freeze runs and service writes biased toward the two keys exercise interrupted and completed sequences in every mode, including the disabled mode.

// File: rtl/svc_wdog_pkg.sv
package svc_wdog_pkg;

  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_FIRST  = 16'h556C;
  localparam logic [KEY_W-1:0] KEY_SECOND = 16'hAA39;

  // bit 3 prescale, bit 2 action (1 = reset), bit 1 freeze response, bit 0 enable
  typedef struct packed {
    logic pre;
    logic act;
    logic frz;
    logic en;
  } wd_cfg_t;

  localparam wd_cfg_t CFG_RST = '{pre: 1'b0, act: 1'b1, frz: 1'b0, en: 1'b1};

endpackage

// File: rtl/svc_wdog_prescale.sv
module svc_wdog_prescale #(
  parameter int DIV = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic pre_en,
  output logic tick
);

  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  generate
    if (DIV > 1) begin : g_div
      logic [DW-1:0] div_q;

      always_ff @(posedge clk) begin
        if (rst || clr) begin
          div_q <= '0;
        end else if (run && pre_en) begin
          div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
        end
      end

      assign tick = run && (!pre_en || div_q == LAST);

      // R2: a paused prescaler keeps its phase
      a_r2_div_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr) |=> $stable(div_q));
    end else begin : g_nodiv
      assign tick = run;
    end
  endgenerate

  // R4: no count step while stopped
  a_r4_no_tick_idle: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tick);

endmodule

// File: rtl/svc_wdog_keyseq.sv
module svc_wdog_keyseq
  import svc_wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [KEY_W-1:0] wdata,
  output logic             done
);

  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
    end else if (we) begin
      armed_q <= (wdata == KEY_FIRST);
    end
  end

  assign done = we && armed_q && (wdata == KEY_SECOND);

  // R6: first key arms, anything else disarms
  a_r6_arm: assert property (@(posedge clk) disable iff (rst)
    (we && wdata == KEY_FIRST) |=> armed_q);
  a_r6_disarm: assert property (@(posedge clk) disable iff (rst)
    (we && wdata != KEY_FIRST) |=> !armed_q);

endmodule

// File: rtl/svc_wdog_counter.sv
module svc_wdog_counter #(
  parameter int CNT_W   = 16,
  parameter int TMO_RST = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             act_reset,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             reload_req,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             nmi_q,
  output logic             rst_q
);

  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(TMO_RST);

  logic expire;
  assign expire = en && !reload_req && tick && (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= CNT_INIT;
      nmi_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      nmi_q <= expire && !act_reset;
      if (expire && act_reset) rst_q <= 1'b1;
      if (!en || reload_req || expire) begin
        count <= reload_val;
      end else if (tick) begin
        count <= count - 1'b1;
      end
    end
  end

  // R7: interrupt request is a single-cycle pulse
  a_r7_nmi_pulse: assert property (@(posedge clk) disable iff (rst)
    (nmi_q && count != '0) |=> !nmi_q);
  // R7: reset request is sticky
  a_r7_rst_sticky: assert property (@(posedge clk) disable iff (rst)
    rst_q |=> rst_q);
  // R8: disabled watchdog raises no interrupt
  a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> !nmi_q);
  // R3: a request only follows a zero count
  a_r3_from_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_q) |-> $past(count) == '0);

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import svc_wdog_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int TMO_RST = 16'hFFFF,
  parameter int PRE_DIV = 2048
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             freeze_in,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_wdata,
  input  logic [CNT_W-1:0] cfg_tmo,
  input  logic             svc_we,
  input  logic [KEY_W-1:0] svc_wdata,
  output logic             nmi_req,
  output logic             rst_req,
  output logic [CNT_W-1:0] rd_count,
  output logic [3:0]       rd_cfg
);

  wd_cfg_t          cfg_q;
  logic [CNT_W-1:0] tmo_q;
  logic             locked_q;
  logic             svc_done;
  logic             run;
  logic             tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= CFG_RST;
      tmo_q    <= CNT_W'(TMO_RST);
      locked_q <= 1'b0;
    end else if (cfg_we && !locked_q) begin
      cfg_q    <= wd_cfg_t'(cfg_wdata);
      tmo_q    <= cfg_tmo;
      locked_q <= 1'b1;
    end
  end

  assign run = cfg_q.en && !(cfg_q.frz && freeze_in);

  svc_wdog_keyseq u_keys (
    .clk   (clk),
    .rst   (rst),
    .we    (svc_we),
    .wdata (svc_wdata),
    .done  (svc_done)
  );

  svc_wdog_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .clr    (!cfg_q.en || svc_done),
    .run    (run),
    .pre_en (cfg_q.pre),
    .tick   (tick)
  );

  svc_wdog_counter #(.CNT_W(CNT_W), .TMO_RST(TMO_RST)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .en         (cfg_q.en),
    .act_reset  (cfg_q.act),
    .reload_val (tmo_q),
    .reload_req (svc_done),
    .tick       (tick),
    .count      (rd_count),
    .nmi_q      (nmi_req),
    .rst_q      (rst_req)
  );

  assign rd_cfg = cfg_q;

  // R5: configuration is frozen after the first write
  a_r5_cfg_locked: assert property (@(posedge clk) disable iff (rst)
    locked_q |=> ($stable(cfg_q) && $stable(tmo_q)));
  // R2: gated freeze holds the count
  a_r2_freeze_hold: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.en && cfg_q.frz && freeze_in && !svc_done && !cfg_we) |=> $stable(rd_count));
  // R6: completed service leaves the timeout in the counter
  a_r6_reload: assert property (@(posedge clk) disable iff (rst)
    (svc_done && !cfg_we) |=> rd_count == $past(tmo_q));

endmodule

// File: tb/svc_watchdog_bench.sv
module svc_watchdog_bench;
  localparam int CW   = 16;
  localparam int TMO  = 40;
  localparam int PDIV = 8;
  localparam logic [15:0] K1 = 16'h556C;
  localparam logic [15:0] K2 = 16'hAA39;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic freeze_in = 1'b0, cfg_we = 1'b0, svc_we = 1'b0;
  logic [3:0] cfg_wdata = '0;
  logic [CW-1:0] cfg_tmo = '0;
  logic [15:0] svc_wdata = '0;
  logic nmi_req, rst_req;
  logic [CW-1:0] rd_count;
  logic [3:0] rd_cfg;

  always #2.5 clk = ~clk;

  svc_watchdog #(.CNT_W(CW), .TMO_RST(TMO), .PRE_DIV(PDIV)) u_svc_watchdog (
    .clk(clk), .rst(rst), .freeze_in(freeze_in), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_tmo(cfg_tmo), .svc_we(svc_we),
    .svc_wdata(svc_wdata), .nmi_req(nmi_req), .rst_req(rst_req),
    .rd_count(rd_count), .rd_cfg(rd_cfg));

  int n_chk = 0, n_bad = 0;
  string cur_req = "R4";

  // expectation state built from the requirements
  logic [3:0] m_cfg;
  logic [CW-1:0] m_tmo, m_cnt;
  int m_div;
  logic m_lock, m_arm, m_nmi, m_rst;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pick_key();
    int r = $urandom_range(0, 9);
    if (r < 4) return K1;
    if (r < 8) return K2;
    return 16'($urandom);
  endfunction

  task automatic model_reset();
    m_cfg = 4'b0101; m_tmo = CW'(TMO); m_cnt = CW'(TMO); m_div = 0;
    m_lock = 0; m_arm = 0; m_nmi = 0; m_rst = 0;
  endtask

  task automatic model_next();
    logic en, frz, act, pre, done, run, tick, exp_;
    en = m_cfg[0]; frz = m_cfg[1]; act = m_cfg[2]; pre = m_cfg[3];
    done = svc_we && m_arm && svc_wdata == K2;
    run  = en && !(frz && freeze_in);
    tick = run && (!pre || m_div == PDIV - 1);
    exp_ = en && !done && tick && m_cnt == 0;
    m_nmi = exp_ && !act;
    if (exp_ && act) m_rst = 1;
    if (!en || done || exp_) m_cnt = m_tmo;
    else if (tick) m_cnt = m_cnt - 1'b1;
    if (!en || done) m_div = 0;
    else if (run && pre) m_div = (m_div == PDIV - 1) ? 0 : m_div + 1;
    if (svc_we) m_arm = (svc_wdata == K1);
    if (cfg_we && !m_lock) begin m_cfg = cfg_wdata; m_tmo = cfg_tmo; m_lock = 1; end
  endtask

  task automatic step();
    model_next();
    @(posedge clk);
    @(negedge clk);
    cfg_we = 0; svc_we = 0;
    chk(cur_req, "count", 32'(rd_count), 32'(m_cnt));
    chk("R3", "nmi_req", 32'(nmi_req), 32'(m_nmi));
    chk("R7", "rst_req", 32'(rst_req), 32'(m_rst));
    chk("R9", "rd_cfg", 32'(rd_cfg), 32'(m_cfg));
  endtask

  task automatic do_reset();
    rst = 1; freeze_in = 0; cfg_we = 0; svc_we = 0;
    @(posedge clk); @(negedge clk);
    model_reset();
    rst = 0;
  endtask

  task automatic write_cfg(logic [3:0] c, logic [CW-1:0] t);
    cfg_we = 1; cfg_wdata = c; cfg_tmo = t; step();
  endtask

  task automatic service(logic [15:0] d);
    svc_we = 1; svc_wdata = d; step();
  endtask

  task automatic random_run(int n);
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(0, 7) == 0) freeze_in = ~freeze_in;
      if ($urandom_range(0, 5) == 0) begin svc_we = 1; svc_wdata = pick_key(); end
      if ($urandom_range(0, 49) == 0) begin cfg_we = 1; cfg_wdata = 4'($urandom); cfg_tmo = 16'($urandom); end
      step();
    end
    freeze_in = 0;
  endtask

  initial begin
    logic [CW-1:0] snap;
    void'($urandom(32'h5EED_0017));
    do_reset();
    // R1: reset state
    chk("R1", "rd_cfg", 32'(rd_cfg), 32'h5);
    chk("R1", "rd_count", 32'(rd_count), TMO);
    chk("R1", "nmi_req", 32'(nmi_req), 0);
    chk("R1", "rst_req", 32'(rst_req), 0);

    // R3: default action is reset, after TMO+1 edges
    cur_req = "R4";
    repeat (TMO) step();
    chk("R3", "rst_req before expiry", 32'(rst_req), 0);
    step();
    chk("R3", "rst_req at expiry", 32'(rst_req), 1);
    repeat (100) step();
    chk("R7", "rst_req sticky", 32'(rst_req), 1);

    // freeze-gated, NMI action, no prescale
    do_reset();
    write_cfg(4'b0011, 16'd12);
    freeze_in = 1;
    snap = rd_count;
    repeat (10) step();
    chk("R2", "count held in freeze", 32'(rd_count), 32'(snap));
    freeze_in = 0;
    step();
    chk("R2", "count resumes", 32'(rd_count), 32'(snap - 1'b1));
    service(K1); service(16'h1234); service(K2);
    chk("R6", "broken sequence no reload", 32'(rd_count), 32'(snap - 4));
    service(K1); service(K2);
    chk("R6", "reload after keys", 32'(rd_count), 12);
    repeat (12) step();
    chk("R3", "nmi before expiry", 32'(nmi_req), 0);
    step();
    chk("R3", "nmi at expiry", 32'(nmi_req), 1);
    step();
    chk("R7", "nmi one cycle", 32'(nmi_req), 0);
    chk("R7", "count reloaded and running", 32'(rd_count), 11);
    write_cfg(4'b0000, 16'd5);
    chk("R5", "second write ignored", 32'(rd_cfg), 32'h3);
    cur_req = "R2";
    random_run(3000);

    // prescaled, freeze-gated, NMI action
    do_reset();
    write_cfg(4'b1011, 16'd3);
    service(K1); service(K2);
    chk("R6", "prescaled reload", 32'(rd_count), 3);
    repeat (PDIV - 1) step();
    chk("R4", "no step before period", 32'(rd_count), 3);
    step();
    chk("R4", "one step per period", 32'(rd_count), 2);
    cur_req = "R4";
    random_run(4000);

    // freeze ignored when freeze-response is 0
    do_reset();
    write_cfg(4'b0001, 16'd100);
    service(K1); service(K2);
    freeze_in = 1;
    repeat (20) step();
    chk("R2", "freeze ignored", 32'(rd_count), 80);
    freeze_in = 0;
    cur_req = "R4";
    random_run(2000);

    // disabled
    do_reset();
    write_cfg(4'b0100, 16'd9);
    step();
    write_cfg(4'b0101, 16'd9);
    chk("R5", "re-enable ignored", 32'(rd_cfg), 32'h4);
    cur_req = "R8";
    random_run(300);
    chk("R8", "count at reload", 32'(rd_count), 9);
    chk("R8", "no reset request", 32'(rst_req), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule